// File: doc/BRIEF.md
# Monotonic Isolation Level Controller

This block holds the isolation level of a staged boot sequence. The level starts at zero after reset and can only rise. Each boot stage hands control to the next by writing a keyed command that names the level to enter. No write can lower the level. Only the power-on reset or the system reset brings it back to zero. There are four levels: the root service (0), the immutable root of trust (1), the updatable root of trust (2) and the user application (3). A command may name any higher level, so a stage can be skipped. For example, an application can start at level 2 or at level 3 when no second boot stage exists.

Every memory region is tagged with the level that owns it. The block answers each access request, whether a data read or an instruction fetch, one cycle later. The access is allowed only when the owner level is at or above the current level. Code and secrets of earlier stages therefore become unreachable once the sequence moves past them. The current level is always present on an output port. Software at any level can also read it back through a status register.

Top module: `iso_level_ctrl`

## Requirements
- R1: While `por_rst` or `sys_rst` is high at a rising clock edge, the next cycle shows `cur_level` = 0, with `err_key`, `err_order` and `resp_valid` all low and `reg_rdata` = 0.
- R2: `cur_level` never decreases from one cycle to the next unless a reset input is high.
- R3: A command write sets `cur_level` to the target on the same clock edge when all of these hold: `reg_wr_en`=1, `reg_addr`=0x0, `reg_wdata[31:16]` equal to the key (default 0xA5C3), and the target `reg_wdata[1:0]` greater than the current level. Jumping over levels is allowed.
- R4: A correctly keyed command whose target is less than or equal to the current level leaves the level unchanged. It raises `err_order` for exactly one cycle. At level 3 every command is of this kind, so the level saturates at 3 and never wraps.
- R5: A command write whose key field differs from the key leaves the level unchanged and raises `err_key` for exactly one cycle.
- R6: A write to any address other than 0x0, the status address 0x4 included, has no effect on the level and raises no flag.
- R7: For each cycle with `acc_valid`=1, the next cycle shows `resp_valid`=1, with `resp_fetch` echoing `acc_fetch` (0 = read, 1 = fetch). `resp_allow` is 1 exactly when `acc_owner` is greater than or equal to the level in the request cycle, and the same rule applies to reads and fetches. In cycles that follow no request, `resp_valid`=0.
- R8: A read with `reg_rd_en`=1 at address 0x4 returns the level of the request cycle, zero-extended, on `reg_rdata` in the next cycle. It does so at every level. Any other read, and any cycle without a read, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | System reset, synchronous, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Write data: key in [31:16], target level in [1:0] |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data, one cycle after the read |
| acc_valid | input | 1 | Access request present |
| acc_owner | input | 2 | Owning level of the addressed region |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data read |
| cur_level | output | 2 | Current isolation level |
| resp_valid | output | 1 | Access response present |
| resp_allow | output | 1 | Access allowed (1) or denied (0) |
| resp_fetch | output | 1 | Echo of the request kind |
| err_key | output | 1 | One-cycle pulse: command with bad key |
| err_order | output | 1 | One-cycle pulse: command not raising the level |

## Verification
The assertions assume that each reset input is held for at least two clock edges before it is released. This ensures the first past value of the level after reset is a defined zero. They also assume that a register write and a register read never meet at the same address in one cycle in a way that would matter; the command and status addresses differ. The stimulus applies every reset for several cycles and drives all inputs only on falling edges. It then walks every start level against every target and every key condition. At each level it sweeps all owner levels for both access kinds.

// File: rtl/iso_level_pkg.sv
package iso_level_pkg;

    localparam int NUM_LEVELS = 4;
    localparam int LVL_W      = $clog2(NUM_LEVELS);
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 32;
    localparam int KEY_W      = 16;
    localparam int KEY_LSB    = DATA_W - KEY_W;

    localparam logic [ADDR_W-1:0] OFS_CMD    = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 4'h4;

    typedef logic [LVL_W-1:0] level_t;

    localparam level_t LEVEL_TOP = level_t'(NUM_LEVELS - 1);

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_FETCH = 1'b1
    } acc_kind_e;

    typedef struct packed {
        logic   valid;
        logic   key_ok;
        level_t target;
    } step_req_t;

    typedef struct packed {
        logic      valid;
        acc_kind_e kind;
        logic      allow;
    } acc_resp_t;

    function automatic logic region_visible(level_t owner, level_t cur);
        return owner >= cur;
    endfunction

    function automatic logic step_is_legal(level_t target, level_t cur);
        return target > cur;
    endfunction

endpackage

// File: rtl/iso_cmd_decode.sv
module iso_cmd_decode
    import iso_level_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY = 16'hA5C3
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output step_req_t         req
);
    logic [KEY_W-1:0] key_field;

    always_comb begin
        key_field  = wdata[DATA_W-1:KEY_LSB];
        req.valid  = wr_en && (addr == OFS_CMD);
        req.key_ok = (key_field == KEY);
        req.target = wdata[LVL_W-1:0];
    end
endmodule

// File: rtl/iso_level_counter.sv
module iso_level_counter
    import iso_level_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  step_req_t req,
    output level_t    level,
    output logic      err_key,
    output logic      err_order
);
    level_t level_q;
    level_t level_d;
    logic   key_d;
    logic   order_d;

    always_comb begin
        level_d = level_q;
        key_d   = 1'b0;
        order_d = 1'b0;
        if (req.valid) begin
            if (!req.key_ok) begin
                key_d = 1'b1;
            end else if (step_is_legal(req.target, level_q)) begin
                level_d = req.target;
            end else begin
                order_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q   <= '0;
            err_key   <= 1'b0;
            err_order <= 1'b0;
        end else begin
            level_q   <= level_d;
            err_key   <= key_d;
            err_order <= order_d;
        end
    end

    assign level = level_q;
endmodule

// File: rtl/iso_access_gate.sv
module iso_access_gate
    import iso_level_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      acc_valid,
    input  level_t    acc_owner,
    input  acc_kind_e acc_kind,
    input  level_t    level,
    output acc_resp_t resp
);
    acc_resp_t resp_d;

    always_comb begin
        resp_d.valid = acc_valid;
        resp_d.kind  = acc_valid ? acc_kind : ACC_READ;
        resp_d.allow = acc_valid && region_visible(acc_owner, level);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp <= '0;
        end else begin
            resp <= resp_d;
        end
    end
endmodule

// File: rtl/iso_level_ctrl.sv
module iso_level_ctrl
    import iso_level_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY = 16'hA5C3
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              sys_rst,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd_en,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              acc_valid,
    input  logic [LVL_W-1:0]  acc_owner,
    input  logic              acc_fetch,
    output logic [LVL_W-1:0]  cur_level,
    output logic              resp_valid,
    output logic              resp_allow,
    output logic              resp_fetch,
    output logic              err_key,
    output logic              err_order
);
    logic      rst;
    step_req_t step_req;
    level_t    level;
    acc_resp_t resp;
    acc_kind_e kind;

    assign rst  = por_rst | sys_rst;
    assign kind = acc_fetch ? ACC_FETCH : ACC_READ;

    iso_cmd_decode #(.KEY(KEY)) u_decode (
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .req   (step_req)
    );

    iso_level_counter u_counter (
        .clk       (clk),
        .rst       (rst),
        .req       (step_req),
        .level     (level),
        .err_key   (err_key),
        .err_order (err_order)
    );

    iso_access_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_owner (acc_owner),
        .acc_kind  (kind),
        .level     (level),
        .resp      (resp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd_en && (reg_addr == OFS_STATUS)) begin
            reg_rdata <= DATA_W'(level);
        end else begin
            reg_rdata <= '0;
        end
    end

    assign cur_level  = level;
    assign resp_valid = resp.valid;
    assign resp_allow = resp.allow;
    assign resp_fetch = (resp.kind == ACC_FETCH);
endmodule

// File: rtl/iso_level_checker.sv
module iso_level_checker
    import iso_level_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY = 16'hA5C3
) (
    input logic              clk,
    input logic              por_rst,
    input logic              sys_rst,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_rd_en,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              acc_valid,
    input logic [LVL_W-1:0]  acc_owner,
    input logic              acc_fetch,
    input logic [LVL_W-1:0]  cur_level,
    input logic              resp_valid,
    input logic              resp_allow,
    input logic              resp_fetch,
    input logic              err_key,
    input logic              err_order
);
    logic any_rst;
    logic cmd_wr;
    logic key_good;
    assign any_rst  = por_rst | sys_rst;
    assign cmd_wr   = reg_wr_en && (reg_addr == OFS_CMD);
    assign key_good = (reg_wdata[DATA_W-1:KEY_LSB] == KEY);

    p_reset_clears_r1: assert property (@(posedge clk)
        any_rst |=> (cur_level == '0) && !err_key && !err_order && !resp_valid && (reg_rdata == '0));

    p_never_down_r2: assert property (@(posedge clk) disable iff (any_rst)
        cur_level >= $past(cur_level));

    p_step_taken_r3: assert property (@(posedge clk) disable iff (any_rst)
        (cmd_wr && key_good && (reg_wdata[LVL_W-1:0] > cur_level))
        |=> (cur_level == $past(reg_wdata[LVL_W-1:0])) && !err_order && !err_key);

    p_step_refused_r4: assert property (@(posedge clk) disable iff (any_rst)
        (cmd_wr && key_good && (reg_wdata[LVL_W-1:0] <= cur_level))
        |=> $stable(cur_level) && err_order);

    p_top_saturates_r4: assert property (@(posedge clk) disable iff (any_rst)
        (cur_level == LEVEL_TOP) |=> (cur_level == LEVEL_TOP));

    p_bad_key_r5: assert property (@(posedge clk) disable iff (any_rst)
        (cmd_wr && !key_good) |=> $stable(cur_level) && err_key && !err_order);

    p_other_addr_r6: assert property (@(posedge clk) disable iff (any_rst)
        (reg_wr_en && (reg_addr != OFS_CMD)) |=> $stable(cur_level) && !err_key && !err_order);

    p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (any_rst)
        $onehot0({err_key, err_order}));

    p_access_answer_r7: assert property (@(posedge clk) disable iff (any_rst)
        acc_valid |=> resp_valid && (resp_fetch == $past(acc_fetch))
                      && (resp_allow == ($past(acc_owner) >= $past(cur_level))));

    p_access_idle_r7: assert property (@(posedge clk) disable iff (any_rst)
        !acc_valid |=> !resp_valid && !resp_allow);

    p_status_read_r8: assert property (@(posedge clk) disable iff (any_rst)
        (reg_rd_en && (reg_addr == OFS_STATUS)) |=> (reg_rdata == DATA_W'($past(cur_level))));

    p_status_quiet_r8: assert property (@(posedge clk) disable iff (any_rst)
        !(reg_rd_en && (reg_addr == OFS_STATUS)) |=> (reg_rdata == '0));
endmodule

bind iso_level_ctrl iso_level_checker #(.KEY(KEY)) u_checker (
    .clk        (clk),
    .por_rst    (por_rst),
    .sys_rst    (sys_rst),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rd_en  (reg_rd_en),
    .reg_rdata  (reg_rdata),
    .acc_valid  (acc_valid),
    .acc_owner  (acc_owner),
    .acc_fetch  (acc_fetch),
    .cur_level  (cur_level),
    .resp_valid (resp_valid),
    .resp_allow (resp_allow),
    .resp_fetch (resp_fetch),
    .err_key    (err_key),
    .err_order  (err_order)
);

// File: tb/iso_level_ctrl_bench.sv
module iso_level_ctrl_bench;
    localparam logic [15:0] KEY = 16'hA5C3;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        sys_rst = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd_en = 1'b0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_owner = '0;
    logic        acc_fetch = 1'b0;
    logic [1:0]  cur_level;
    logic        resp_valid, resp_allow, resp_fetch, err_key, err_order;

    int total = 0;
    int bad = 0;
    int exp_level = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    iso_level_ctrl #(.KEY(KEY)) u_iso_level_ctrl (
        .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .acc_owner(acc_owner), .acc_fetch(acc_fetch),
        .cur_level(cur_level), .resp_valid(resp_valid), .resp_allow(resp_allow),
        .resp_fetch(resp_fetch), .err_key(err_key), .err_order(err_order)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(bit use_por);
        @(negedge clk);
        if (use_por) por_rst = 1'b1; else sys_rst = 1'b1;
        repeat (3) @(negedge clk);
        por_rst = 1'b0;
        sys_rst = 1'b0;
        exp_level = 0;
        check("R1 level", cur_level, 0);
        check("R1 flags", {err_key, err_order, resp_valid}, 0);
        check("R1 rdata", reg_rdata, 0);
    endtask

    // drive one write, then sample the cycle after the edge
    task automatic write_reg(logic [3:0] a, logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic command(logic [15:0] k, int target);
        bit key_ok;
        bit legal;
        key_ok = (k == KEY);
        legal  = key_ok && (target > exp_level);
        write_reg(4'h0, {k, 14'h0, 2'(target)});
        if (legal) exp_level = target;
        check(key_ok ? (legal ? "R3 level" : "R4 level") : "R5 level", cur_level, exp_level);
        check("R4 err_order", err_order, int'(key_ok && !legal));
        check("R5 err_key", err_key, int'(!key_ok));
        @(negedge clk);
        check("R4 pulse one cycle", {err_key, err_order}, 0);
        check("R2 level kept", cur_level, exp_level);
    endtask

    task automatic sweep_access();
        for (int kind = 0; kind < 2; kind++) begin
            for (int own = 0; own < 4; own++) begin
                acc_valid = 1'b1;
                acc_owner = 2'(own);
                acc_fetch = kind[0];
                @(negedge clk);
                acc_valid = 1'b0;
                check("R7 valid", resp_valid, 1);
                check("R7 allow", resp_allow, int'(own >= exp_level));
                check("R7 kind", resp_fetch, kind);
            end
        end
        @(negedge clk);
        check("R7 idle", resp_valid, 0);
    endtask

    task automatic read_status(logic [3:0] a);
        reg_rd_en = 1'b1;
        reg_addr  = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        check("R8 rdata", reg_rdata, (a == 4'h4) ? exp_level : 0);
        @(negedge clk);
        check("R8 rdata idle", reg_rdata, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_rst = 1'b0;
        @(negedge clk);
        check("R1 level after power-on", cur_level, 0);

        for (int start = 0; start < 4; start++) begin
            for (int tgt = 0; tgt < 4; tgt++) begin
                do_reset(((start + tgt) % 2) == 0);
                if (start > 0) command(KEY, start);
                check("R3 reached start", cur_level, start);
                sweep_access();
                read_status(4'h4);
                read_status(4'h8);
                command(KEY ^ 16'h0001, 3);
                command(16'h0000, tgt);
                write_reg(4'h4, {KEY, 16'h0003});
                check("R6 level", cur_level, exp_level);
                check("R6 flags", {err_key, err_order}, 0);
                write_reg(4'hC, {KEY, 16'h0003});
                check("R6 other addr", cur_level, exp_level);
                command(KEY, tgt);
                sweep_access();
                read_status(4'h4);
            end
        end

        // saturate at the top and hammer it
        do_reset(1'b0);
        command(KEY, 3);
        for (int t = 0; t < 4; t++) command(KEY, t);
        check("R4 saturated", cur_level, 3);

        // mid-sequence system reset
        command(KEY, 3);
        do_reset(1'b0);
        command(KEY, 1);
        command(KEY, 2);
        check("R3 stepwise", cur_level, 2);
        do_reset(1'b1);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule